// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and calendar date as eight packed-BCD bytes: hundredths of a second, seconds, minutes, hours, day of the week, date, month and two-digit year. A one-cycle tick enable, asserted at 100 Hz by logic outside the block, advances the time by one hundredth. Each rollover ripples upward through the fields in the same cycle. Hours count in either a 12-hour format with an AM/PM flag or a 24-hour format, chosen by a bit in the hours byte. The date wraps at the true end of each month and allows February 29 in leap years.

The whole time image is always visible as one 64-bit word. Software or a serial front end can overwrite it in one cycle through a parallel load. The day byte also holds two control bits. One stops the count. The other is stored for the access logic, which uses it to gate an external reset pin. Bits that have no meaning in a byte are held at zero.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the image is 64'h0001_0131_0000_0000. That is year 00, month 01, date 01, day 1 with both control bits set, hours 00 in 24-hour mode, and minutes, seconds and hundredths all 00.
- R2: Byte k of the image sits at bits 8k+7..8k. The bytes are: 0 hundredths 00-99, 1 seconds 00-59, 2 minutes 00-59, 3 hours, 4 day, 5 date, 6 month, 7 year. A tick while running adds one hundredth. Each field that rolls over (hundredths at 99, seconds and minutes at 59) returns to 00 and carries into the next byte.
- R3: With hours bit 7 clear (24-hour mode), bits 5..4 hold the tens digit and the range is 00-23. A carry into 23 gives 00 and advances the date.
- R4: With hours bit 7 set (12-hour mode), bit 5 is PM, bit 4 is the tens digit and the range is 01-12. A carry into 11 gives 12 and toggles bit 5. A carry into 12 gives 01. The date advances only when 11 PM becomes 12 AM.
- R5: Day bits 2..0 count 1 to 7 and wrap to 1 on every date advance. Day bit 4 (reset-pin enable) and bit 5 (stop) are not changed by counting.
- R6: While day bit 5 is 1, ticks change nothing. While it is 0, ticks count.
- R7: April, June, September and November end on 30. February ends on 28, or on 29 when the BCD year is a multiple of 4. Every other month ends on 31. The last date of a month advances to 01 and increments the month. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R8: A load writes load_data, ANDed with the mask below, into the image on the next edge. The load wins over a tick in the same cycle.
- R9: Unused bits always read 0. The per-byte masks are: hundredths FF, seconds 7F, minutes 7F, hours BF, day 37, date 3F, month 1F, year FF. The full mask is 64'hFF1F_3F37_BF7F_7FFF.
- R10: A cycle with neither tick nor load leaves the image unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 100 Hz advance strobe |
| load_en | input | 1 | Parallel load strobe |
| load_data | input | 64 | Image to load, byte 0 in the low bits |
| time_image | output | 64 | Current packed-BCD time and date image |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, eight registers, and both control bits set at reset. This is the only shape the image format allows, so every carry path from hundredths up to the year exists in the build. Random loads often start fields just short of rollover, such as 23:59:59.9x on the last day of a month. This brings date, month and year carries within a few ticks, in both hour formats. Directed loads cover leap and non-leap February, the 12-hour noon and midnight crossings, and the end of the century.

// File: rtl/cal_pkg.sv
package cal_pkg;

   localparam int unsigned CAL_BYTE_W = 8;
   localparam int unsigned CAL_BYTES  = 8;
   localparam int unsigned CAL_IMG_W  = CAL_BYTE_W * CAL_BYTES;

   // bits that may be nonzero in each byte, byte 7 in the top
   localparam logic [CAL_IMG_W-1:0] CAL_IMG_MASK = 64'hFF1F_3F37_BF7F_7FFF;

   // slots of the four plain two-digit counters and their top values
   function automatic int unsigned plain_slot(input int unsigned g);
      return (g == 3) ? 7 : g;
   endfunction

   function automatic logic [7:0] plain_top(input int unsigned g);
      return (g == 0 || g == 3) ? 8'h99 : 8'h59;
   endfunction

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
      else                return {v[7:4], v[3:0] + 4'h1};
   endfunction

   // two-digit BCD year divisible by four
   function automatic logic is_leap(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
      else      return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] m, input logic leap);
      case (m)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
   parameter int unsigned      WIDTH   = 8,
   parameter logic [WIDTH-1:0] TOP_VAL = 8'h59,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] val
);
   import cal_pkg::*;

   logic [WIDTH-1:0] nxt;

   always_comb begin
      nxt = val;
      if (load)     nxt = load_val;
      else if (inc) nxt = (val == TOP_VAL) ? '0 : WIDTH'(bcd_inc(8'(val)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) val <= RST_VAL;
      else        val <= nxt;
   end
endmodule

// File: rtl/cal_hour_field.sv
module cal_hour_field (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       load,
   input  logic [7:0] load_val,
   output logic [7:0] val,
   output logic       day_carry
);
   import cal_pkg::*;

   logic       mode12;
   logic [7:0] hr12;
   logic [7:0] hr24;
   logic [4:0] hr12_nx;
   logic [5:0] hr24_nx;
   logic [7:0] step_val;
   logic [7:0] nxt;

   always_comb begin
      mode12  = val[7];
      hr12    = {3'b000, val[4:0]};
      hr24    = {2'b00, val[5:0]};
      hr12_nx = 5'(bcd_inc(hr12));
      hr24_nx = 6'(bcd_inc(hr24));
      if (mode12) begin
         if (hr12 == 8'h12)      step_val = {val[7], 1'b0, val[5], 5'h01};
         else if (hr12 == 8'h11) step_val = {val[7], 1'b0, ~val[5], 5'h12};
         else                    step_val = {val[7], 1'b0, val[5], hr12_nx};
      end else begin
         if (hr24 == 8'h23)      step_val = 8'h00;
         else                    step_val = {2'b00, hr24_nx};
      end
      day_carry = inc & (mode12 ? ((hr12 == 8'h11) & val[5]) : (hr24 == 8'h23));
      nxt = val;
      if (load)     nxt = load_val;
      else if (inc) nxt = step_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) val <= 8'h00;
      else        val <= nxt;
   end
endmodule

// File: rtl/cal_date_field.sv
module cal_date_field #(
   parameter logic [1:0] CTRL_RST = 2'b11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       load,
   input  logic [7:0] load_day,
   input  logic [7:0] load_date,
   input  logic [7:0] load_month,
   input  logic [7:0] year_bcd,
   output logic [7:0] day_q,
   output logic [7:0] date_q,
   output logic [7:0] month_q,
   output logic       year_inc
);
   import cal_pkg::*;

   logic [7:0] last_date;
   logic       at_end;
   logic       at_dec;
   logic [2:0] dow_nx;

   always_comb begin
      last_date = month_last(month_q, is_leap(year_bcd));
      at_end    = (date_q == last_date);
      at_dec    = (month_q == 8'h12);
      dow_nx    = (day_q[2:0] == 3'd7) ? 3'd1 : day_q[2:0] + 3'd1;
      year_inc  = inc & at_end & at_dec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         day_q   <= {2'b00, CTRL_RST, 4'h1};
         date_q  <= 8'h01;
         month_q <= 8'h01;
      end else if (load) begin
         day_q   <= load_day;
         date_q  <= load_date;
         month_q <= load_month;
      end else if (inc) begin
         day_q   <= {day_q[7:3], dow_nx};
         if (at_end) begin
            date_q  <= 8'h01;
            month_q <= at_dec ? 8'h01 : bcd_inc(month_q);
         end else begin
            date_q  <= bcd_inc(date_q);
         end
      end
   end
endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned NUM_REGS = 8,
   parameter logic [1:0]  CTRL_RST = 2'b11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_en,
   input  logic                      load_en,
   input  logic [REG_W*NUM_REGS-1:0] load_data,
   output logic [REG_W*NUM_REGS-1:0] time_image
);
   import cal_pkg::*;

   localparam int unsigned IMG_W    = REG_W * NUM_REGS;
   localparam int unsigned N_PLAIN  = 4;
   localparam int unsigned STOP_BIT = 4 * REG_W + 5;

   if (REG_W != CAL_BYTE_W || NUM_REGS != CAL_BYTES) begin : g_bad_shape
      $error("bcd_calendar_clock: image format needs eight 8-bit registers");
   end

   logic [IMG_W-1:0]          ld_img;
   logic                      run;
   logic                      step;
   logic [N_PLAIN-1:0]        plain_inc;
   logic [N_PLAIN-1:0][7:0]   plain_val;
   logic                      hour_inc;
   logic                      date_inc;
   logic                      year_inc;
   logic [7:0]                hour_q;
   logic [7:0]                day_q;
   logic [7:0]                date_q;
   logic [7:0]                month_q;

   assign ld_img = load_data & CAL_IMG_MASK;
   assign run    = ~day_q[5];
   assign step   = tick_en & run & ~load_en;

   // ripple of carries from hundredths to hours, year fed by the date block
   always_comb begin
      plain_inc[0] = step;
      plain_inc[1] = plain_inc[0] & (plain_val[0] == plain_top(0));
      plain_inc[2] = plain_inc[1] & (plain_val[1] == plain_top(1));
      hour_inc     = plain_inc[2] & (plain_val[2] == plain_top(2));
      plain_inc[3] = year_inc;
   end

   for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
      localparam int unsigned SLOT = plain_slot(g);
      cal_bcd_field #(
         .WIDTH   (REG_W),
         .TOP_VAL (plain_top(g)),
         .RST_VAL ('0)
      ) u_field (
         .clk      (clk),
         .rst_n    (rst_n),
         .inc      (plain_inc[g]),
         .load     (load_en),
         .load_val (ld_img[SLOT*REG_W +: REG_W]),
         .val      (plain_val[g])
      );
   end

   cal_hour_field u_hour (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (hour_inc),
      .load      (load_en),
      .load_val  (ld_img[3*REG_W +: REG_W]),
      .val       (hour_q),
      .day_carry (date_inc)
   );

   cal_date_field #(.CTRL_RST(CTRL_RST)) u_date (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc        (date_inc),
      .load       (load_en),
      .load_day   (ld_img[4*REG_W +: REG_W]),
      .load_date  (ld_img[5*REG_W +: REG_W]),
      .load_month (ld_img[6*REG_W +: REG_W]),
      .year_bcd   (plain_val[3]),
      .day_q      (day_q),
      .date_q     (date_q),
      .month_q    (month_q),
      .year_inc   (year_inc)
   );

   assign time_image = {plain_val[3], month_q, date_q, day_q,
                        hour_q, plain_val[2], plain_val[1], plain_val[0]};

   if (STOP_BIT >= IMG_W) begin : g_bad_stop
      $error("bcd_calendar_clock: stop bit outside image");
   end
endmodule

// File: rtl/cal_clock_checker.sv
module cal_clock_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        tick_en,
   input logic        load_en,
   input logic [63:0] load_data,
   input logic [63:0] time_image
);
   import cal_pkg::*;

   // R10
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !load_en) |=> $stable(time_image));

   // R6
   a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (time_image[37] && !load_en) |=> $stable(time_image));

   // R8
   a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> (time_image == ($past(load_data) & CAL_IMG_MASK)));

   // R9
   a_r9_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      ((time_image & ~CAL_IMG_MASK) == 64'h0));

   // R2
   a_r2_hund_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !load_en && !time_image[37] && time_image[3:0] != 4'h9)
      |=> (time_image[3:0] == $past(time_image[3:0]) + 4'h1));

   // R5
   a_r5_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> (time_image[37:36] == $past(time_image[37:36])));
endmodule

bind bcd_calendar_clock cal_clock_checker chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .load_en    (load_en),
   .load_data  (load_data),
   .time_image (time_image)
);

// File: tb/bcd_calendar_clock_tb_top.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb_top;

   localparam logic [63:0] MASK    = 64'hFF1F_3F37_BF7F_7FFF;
   localparam logic [63:0] RST_IMG = 64'h0001_0131_0000_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        tick_en;
   logic        load_en;
   logic [63:0] load_data;
   logic [63:0] time_image;

   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;
   logic [63:0] exp_img;

   always #4 clk = ~clk;

   bcd_calendar_clock dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .load_en    (load_en),
      .load_data  (load_data),
      .time_image (time_image)
   );

   function automatic logic [7:0] to_bcd(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int days_in(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [63:0] mk(input int yr, input int mo, input int dt,
                                      input int dow, input logic [1:0] ctrl,
                                      input logic [7:0] hour_b, input int mi,
                                      input int se, input int hu);
      logic [7:0] day_b;
      day_b = {2'b00, ctrl, 1'b0, 3'(dow)};
      return {to_bcd(yr), to_bcd(mo), to_bcd(dt), day_b,
              hour_b, to_bcd(mi), to_bcd(se), to_bcd(hu)};
   endfunction

   // expected next image after one running tick, in integer arithmetic
   function automatic logic [63:0] model_step(input logic [63:0] im);
      int hu, se, mi, hr, dt, mo, yr, dow;
      bit m12, pm, new_day;
      logic [7:0] hb, tmp, hour_b;
      hu = from_bcd(im[7:0]);   se = from_bcd(im[15:8]);
      mi = from_bcd(im[23:16]); hb = im[31:24];
      dt = from_bcd(im[47:40]); mo = from_bcd(im[55:48]);
      yr = from_bcd(im[63:56]); dow = int'(im[34:32]);
      m12 = hb[7]; pm = hb[5];
      hr = m12 ? (int'(hb[4]) * 10 + int'(hb[3:0]))
               : (int'(hb[5:4]) * 10 + int'(hb[3:0]));
      new_day = 1'b0;
      hu++;
      if (hu == 100) begin
         hu = 0; se++;
         if (se == 60) begin
            se = 0; mi++;
            if (mi == 60) begin
               mi = 0;
               if (m12) begin
                  if (hr == 11) begin hr = 12; new_day = pm; pm = !pm; end
                  else if (hr == 12) hr = 1;
                  else hr++;
               end else begin
                  hr++;
                  if (hr == 24) begin hr = 0; new_day = 1'b1; end
               end
            end
         end
      end
      if (new_day) begin
         dow = (dow == 7) ? 1 : dow + 1;
         if (dt == days_in(mo, yr)) begin
            dt = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
         end else dt++;
      end
      tmp = to_bcd(hr);
      hour_b = m12 ? {1'b1, 1'b0, pm, tmp[4:0]} : {2'b00, tmp[5:0]};
      return mk(yr, mo, dt, dow, im[37:36], hour_b, mi, se, hu);
   endfunction

   function automatic logic [63:0] rand_img();
      int yr, mo, dt, dow, mi, se, hu, hr;
      bit m12, pm;
      logic [7:0] hb, t;
      m12 = 1'($urandom % 2); pm = 1'($urandom % 2);
      yr = $urandom % 100; mo = 1 + $urandom % 12;
      dt = 1 + $urandom % days_in(mo, yr); dow = 1 + $urandom % 7;
      mi = $urandom % 60; se = $urandom % 60; hu = $urandom % 100;
      hr = m12 ? 1 + $urandom % 12 : $urandom % 24;
      if ($urandom % 3 == 0) begin
         hu = 90 + $urandom % 10; se = 59; mi = 59;
         hr = m12 ? 11 : 23; dt = days_in(mo, yr);
         if ($urandom % 2 == 0) mo = 12;
         if (mo == 12) dt = 31;
      end
      t = to_bcd(hr);
      hb = m12 ? {1'b1, 1'b0, pm, t[4:0]} : {2'b00, t[5:0]};
      return mk(yr, mo, dt, dow, {1'b0, 1'($urandom % 2)}, hb, mi, se, hu);
   endfunction

   task automatic check_img(input string req, input logic [63:0] want);
      checks++;
      if (time_image !== want) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, time_image, want);
      end
   endtask

   task automatic cyc(input bit tk, input bit ld, input logic [63:0] d,
                      input string req);
      @(negedge clk);
      tick_en = tk; load_en = ld; load_data = d;
      @(posedge clk);
      #1;
      if (ld)                   exp_img = d & MASK;
      else if (tk && !exp_img[37]) exp_img = model_step(exp_img);
      check_img(req, exp_img);
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = 32'h1216;
      void'($urandom(seed));
      rst_n = 1'b0; tick_en = 1'b0; load_en = 1'b0; load_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      exp_img = RST_IMG;
      check_img("R1 reset image", RST_IMG);

      // R6: stopped after reset, ticks ignored
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, '0, "R6 stopped at reset");

      // R9: load all ones, masked bits read zero
      cyc(1'b0, 1'b1, '1, "R9 masked load");
      check_img("R9 mask literal", MASK);

      // R8: load and tick together, load wins
      cyc(1'b1, 1'b1, mk(20, 5, 10, 3, 2'b00, 8'h08, 30, 15, 42), "R8 load over tick");
      check_img("R8 literal", 64'h2005_1003_0830_1542);
      // R10: idle cycles
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, '0, "R10 idle hold");
      cyc(1'b1, 1'b0, '0, "R2 single tick");
      check_img("R2 literal", 64'h2005_1003_0830_1543);

      // R3: 24-hour day end
      cyc(1'b0, 1'b1, mk(45, 6, 15, 4, 2'b01, 8'h23, 59, 59, 99), "R3 load");
      cyc(1'b1, 1'b0, '0, "R3 day carry");
      check_img("R3 literal", 64'h4506_1615_0000_0000);

      // R4: 12-hour crossings
      cyc(1'b0, 1'b1, mk(10, 3, 3, 2, 2'b00, 8'h91, 59, 59, 99), "R4 load AM");
      cyc(1'b1, 1'b0, '0, "R4 11 AM to 12 PM");
      check_img("R4 noon literal", 64'h1003_0302_B200_0000);
      cyc(1'b0, 1'b1, mk(10, 3, 3, 7, 2'b00, 8'hB1, 59, 59, 99), "R4 load PM");
      cyc(1'b1, 1'b0, '0, "R4 11 PM to 12 AM");
      check_img("R4 midnight literal R5 wrap", 64'h1003_0401_9200_0000);
      cyc(1'b0, 1'b1, mk(10, 3, 3, 2, 2'b00, 8'hB2, 59, 59, 99), "R4 load 12 PM");
      cyc(1'b1, 1'b0, '0, "R4 12 to 01");
      check_img("R4 one literal", 64'h1003_0302_A100_0000);

      // R7: month lengths and leap years
      cyc(1'b0, 1'b1, mk(23, 2, 28, 1, 2'b00, 8'h23, 59, 59, 99), "R7 load");
      cyc(1'b1, 1'b0, '0, "R7 feb non-leap");
      check_img("R7 mar literal", 64'h2303_0102_0000_0000);
      cyc(1'b0, 1'b1, mk(24, 2, 28, 1, 2'b00, 8'h23, 59, 59, 99), "R7 load");
      cyc(1'b1, 1'b0, '0, "R7 feb 29 leap");
      check_img("R7 feb29 literal", 64'h2402_2902_0000_0000);
      cyc(1'b0, 1'b1, mk(0, 2, 29, 1, 2'b00, 8'h23, 59, 59, 99), "R7 load");
      cyc(1'b1, 1'b0, '0, "R7 leap feb end");
      cyc(1'b0, 1'b1, mk(50, 4, 30, 1, 2'b00, 8'h23, 59, 59, 99), "R7 load");
      cyc(1'b1, 1'b0, '0, "R7 april end");
      check_img("R7 may literal", 64'h5005_0102_0000_0000);
      cyc(1'b0, 1'b1, mk(50, 1, 30, 1, 2'b00, 8'h23, 59, 59, 99), "R7 load");
      cyc(1'b1, 1'b0, '0, "R7 jan 30 to 31");
      cyc(1'b0, 1'b1, mk(99, 12, 31, 7, 2'b00, 8'h23, 59, 59, 99), "R7 load");
      cyc(1'b1, 1'b0, '0, "R7 century end");
      check_img("R7 year wrap literal", 64'h0001_0101_0000_0000);

      // R5: control bit kept through counting, R6 stop mid-run
      cyc(1'b0, 1'b1, mk(7, 7, 7, 6, 2'b01, 8'h23, 59, 59, 99), "R5 load");
      cyc(1'b1, 1'b0, '0, "R5 ctrl kept");
      check_img("R5 literal", 64'h0707_0817_0000_0000);
      cyc(1'b0, 1'b1, mk(7, 7, 7, 6, 2'b10, 8'h12, 34, 56, 78), "R6 load stopped");
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, '0, "R6 stopped hold");
      check_img("R6 literal", 64'h0707_0726_1234_5678);

      // R2: random images and tick patterns
      for (int n = 0; n < 40; n++) begin
         cyc(1'b0, 1'b1, rand_img(), "R8 random load");
         for (int k = 0; k < 200; k++)
            cyc(1'($urandom % 4 != 0), 1'b0, '0, "R2 random run");
      end

      @(negedge clk); tick_en = 1'b0; load_en = 1'b0;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule